// File: doc/BRIEF.md
# Load Queue with Memory-Ordering Violation Detection

This block tracks in-flight loads of an out-of-order core. Each load takes a slot when it is dispatched, in program order, and carries a sequence number. When the load executes, its effective address is written into its slot. Each load also has a ready-to-issue flag, which is set when it is allocated or later through a wake port. The block reports how many allocated loads are ready but have not yet executed.

When a store executes, the queue compares that store against every executed load that is younger than it. Two addresses match when they agree above a 256-byte boundary. If any load matches, that load went ahead of an older store to the same region and read stale data. The oldest such load is recorded as the violator and the store check reports a fault. The core then reads the violator to start a squash and refetch. While a violator is waiting to be read, later store checks are not searched.

Commit frees slots from the oldest end of the queue. Squash frees slots from the youngest end. A combined free-entry figure is computed from this queue's own occupancy and from the occupancy of the companion store queue, which is supplied as an input. One slot is held back from that figure.

Top module: `ldq_order_guard`

## Requirements
- R1: After reset the queue holds no loads, no violator is recorded, `st_done` and `st_fault` are 0, and `alloc_idx` is 0.
- R2: Slots are handed out in ring order. A new load takes slot (oldest slot + occupancy) mod DEPTH, and that index is shown on `alloc_idx`. `lq_full` is 1 when all DEPTH slots are taken. An allocation request is ignored when the queue is full at the start of the cycle.
- R3: An address update to an occupied slot stores the address and marks the load as executed. An address update or wake to an unoccupied slot has no effect.
- R4: A store check considers only executed loads whose sequence number is strictly greater than the store's. A load's address matches the store's when bits [ADDR_W-1:GRAN_SHIFT] are equal. GRAN_SHIFT defaults to 8.
- R5: When at least one load matches, `st_done` and `st_fault` are 1 one cycle after the check. In the same cycle the oldest matching load's slot and sequence number appear on `viol_idx` and `viol_seq`, and `viol_valid` is 1.
- R6: While `viol_valid` is 1, a store check does no search. It returns `st_done`=1 and `st_fault`=0 and leaves the record unchanged. Asserting `viol_rd` clears the record at the next edge unless the same cycle records a new violator.
- R7: When a store check finds no match, it returns `st_done`=1 with `st_fault`=0, and no violator is recorded.
- R8: A commit frees, in a single cycle, every load at the oldest end of the queue in an unbroken run whose sequence numbers are less than or equal to `cm_seq`.
- R9: A squash frees every load whose sequence number is greater than `sq_seq`. In a squash cycle, allocation, commit, address update, wake and store check are all ignored.
- R10: `free_slots` equals min(DEPTH − occupancy, SQ_DEPTH − `sq_used`) − 1, with a floor of 0.
- R11: `ready_cnt` counts occupied loads that are ready and not yet executed. A wake to an occupied slot sets that load's ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate a new load |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_rdy | input | 1 | New load is ready to issue at allocation |
| alloc_idx | output | IDX_W | Slot that the next allocation takes |
| lq_full | output | 1 | All slots are occupied |
| upd_valid | input | 1 | Record an executed load's address |
| upd_idx | input | IDX_W | Slot to update |
| upd_addr | input | ADDR_W | Effective address |
| wk_valid | input | 1 | Mark a load ready to issue |
| wk_idx | input | IDX_W | Slot to wake |
| st_valid | input | 1 | Store check request |
| st_seq | input | SEQ_W | Store sequence number |
| st_addr | input | ADDR_W | Store effective address |
| st_done | output | 1 | A store check completed in the previous cycle |
| st_fault | output | 1 | That check found an ordering violation |
| viol_rd | input | 1 | Read and clear the violator record |
| viol_valid | output | 1 | A violator is recorded |
| viol_idx | output | IDX_W | Violator slot |
| viol_seq | output | SEQ_W | Violator sequence number |
| cm_valid | input | 1 | Commit request |
| cm_seq | input | SEQ_W | Youngest committed sequence number |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Loads younger than this are removed |
| sq_used | input | SQ_CNT_W | Store-queue occupancy |
| ld_count | output | CNT_W | Number of occupied slots |
| ready_cnt | output | CNT_W | Loads ready but not executed |
| free_slots | output | FREE_W | Combined free-entry figure |

## Verification
The bench builds the block with DEPTH=4, SQ_DEPTH=6, SEQ_W=12, ADDR_W=16 and GRAN_SHIFT=8. With a four-slot ring, a few allocations are enough to fill the queue and to wrap the head past the last slot. This brings the full-queue refusal and the wrapped oldest-first search order within reach of both the directed cases and the random phase. The 16-bit addresses give only 256 regions, so the random phase uses just four of them. As a result, both matches and near misses just outside a region are frequent. Because SQ_DEPTH is larger than DEPTH, either term of the free-entry minimum can be the smaller one, and `sq_used` can drive the result down to its floor of 0.

// File: rtl/ldq_pkg.sv
// ldq_pkg: shared types and helpers for the load queue.
// Assumes: nothing beyond IEEE 1800-2017 elaboration.
package ldq_pkg;

    // Outcome of a store check in one cycle.
    typedef enum logic [1:0] {
        CHK_NONE  = 2'd0,   // no check this cycle
        CHK_CLEAN = 2'd1,   // searched, no younger load matched
        CHK_HIT   = 2'd2,   // searched, violator found
        CHK_SKIP  = 2'd3    // record pending, search suppressed
    } chk_res_e;

    // Smaller of two non-negative counts.
    function automatic int lesser(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/ldq_age_ctrl.sv
// ldq_age_ctrl: ring head and occupancy of the load queue.
// Computes how many loads a commit frees from the oldest end and how many
// a squash frees from the youngest end, both in a single cycle.
// Assumes: DEPTH is a power of two and at least 2. Sequence numbers increase
// in program order and do not wrap while loads are in the queue.
module ldq_age_ctrl #(
    parameter  int DEPTH = 8,
    parameter  int SEQ_W = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic             cm_valid,
    input  logic [SEQ_W-1:0] cm_seq,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq,
    input  logic [SEQ_W-1:0] seq_arr [DEPTH],
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             alloc_fire,
    output logic [DEPTH-1:0] occ
);

    logic [IDX_W-1:0] head_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] cm_n;
    logic [CNT_W-1:0] cm_eff;
    logic [CNT_W-1:0] sq_n;
    logic             cm_run;
    logic             sq_run;
    logic [IDX_W-1:0] off_v;

    assign head  = head_q;
    assign count = count_q;
    assign tail  = head_q + count_q[IDX_W-1:0];

    // Allocation is accepted only when a slot is free and no squash is active.
    assign alloc_fire = alloc_valid && !sq_valid && (count_q != CNT_W'(DEPTH));

    // Length of the run of committable loads, counted from the head.
    always_comb begin
        cm_n   = '0;
        cm_run = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            if (cm_run && (CNT_W'(k) < count_q) &&
                (seq_arr[head_q + IDX_W'(k)] <= cm_seq)) begin
                cm_n = cm_n + CNT_W'(1);
            end else begin
                cm_run = 1'b0;
            end
        end
    end

    assign cm_eff = cm_valid ? cm_n : '0;

    // Length of the run of squashed loads, counted back from the tail.
    always_comb begin
        sq_n   = '0;
        sq_run = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            if (sq_run && (CNT_W'(k) < count_q) &&
                (seq_arr[tail - IDX_W'(k + 1)] > sq_seq)) begin
                sq_n = sq_n + CNT_W'(1);
            end else begin
                sq_run = 1'b0;
            end
        end
    end

    // Per-slot occupancy from the slot's distance to the head.
    always_comb begin
        occ   = '0;
        off_v = '0;
        for (int i = 0; i < DEPTH; i++) begin
            off_v  = IDX_W'(i) - head_q;
            occ[i] = (CNT_W'(off_v) < count_q);
        end
    end

    // Advance the head and occupancy. A squash takes precedence over everything else.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            count_q <= '0;
        end else if (sq_valid) begin
            count_q <= count_q - sq_n;
        end else begin
            head_q  <= head_q + cm_eff[IDX_W-1:0];
            count_q <= count_q - cm_eff + CNT_W'(alloc_fire);
        end
    end

endmodule

// File: rtl/ldq_slot_store.sv
// ldq_slot_store: per-slot load state (sequence number, address,
// executed flag, ready flag).
// Assumes: the slot being allocated is always unoccupied. Updates and wakes
// are ignored for unoccupied slots and during a squash.
module ldq_slot_store #(
    parameter  int DEPTH  = 8,
    parameter  int SEQ_W  = 16,
    parameter  int ADDR_W = 32,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_fire,
    input  logic [IDX_W-1:0]  tail,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic              alloc_rdy,
    input  logic              upd_valid,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              wk_valid,
    input  logic [IDX_W-1:0]  wk_idx,
    input  logic              sq_valid,
    input  logic [DEPTH-1:0]  occ,
    output logic [SEQ_W-1:0]  seq_arr  [DEPTH],
    output logic [ADDR_W-1:0] addr_arr [DEPTH],
    output logic [DEPTH-1:0]  exec_vec,
    output logic [DEPTH-1:0]  rdy_vec
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [SEQ_W-1:0]  seq_q;
        logic [ADDR_W-1:0] addr_q;
        logic              exec_q;
        logic              rdy_q;

        // Write this slot on allocation, address update or wake.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seq_q  <= '0;
                addr_q <= '0;
                exec_q <= 1'b0;
                rdy_q  <= 1'b0;
            end else if (alloc_fire && (tail == IDX_W'(i))) begin
                seq_q  <= alloc_seq;
                addr_q <= '0;
                exec_q <= 1'b0;
                rdy_q  <= alloc_rdy;
            end else if (!sq_valid && occ[i]) begin
                if (upd_valid && (upd_idx == IDX_W'(i))) begin
                    addr_q <= upd_addr;
                    exec_q <= 1'b1;
                end
                if (wk_valid && (wk_idx == IDX_W'(i))) begin
                    rdy_q <= 1'b1;
                end
            end
        end

        assign seq_arr[i]  = seq_q;
        assign addr_arr[i] = addr_q;
        assign exec_vec[i] = exec_q;
        assign rdy_vec[i]  = rdy_q;
    end

endmodule

// File: rtl/ldq_viol_search.sv
// ldq_viol_search: matches a store against younger executed loads, picks the
// oldest matching load and holds it as the violator until it is read.
// Assumes: the search completes in the same cycle and its result is
// registered. Loads that have not executed never match.
module ldq_viol_search
    import ldq_pkg::*;
#(
    parameter  int DEPTH      = 8,
    parameter  int SEQ_W      = 16,
    parameter  int ADDR_W     = 32,
    parameter  int GRAN_SHIFT = 8,
    localparam int IDX_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [SEQ_W-1:0]  st_seq,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              sq_valid,
    input  logic              viol_rd,
    input  logic [IDX_W-1:0]  head,
    input  logic [DEPTH-1:0]  occ,
    input  logic [DEPTH-1:0]  exec_vec,
    input  logic [SEQ_W-1:0]  seq_arr  [DEPTH],
    input  logic [ADDR_W-1:0] addr_arr [DEPTH],
    output logic              st_done,
    output logic              st_fault,
    output logic              viol_valid,
    output logic [IDX_W-1:0]  viol_idx,
    output logic [SEQ_W-1:0]  viol_seq
);

    logic [DEPTH-1:0] hit_vec;
    logic             hit_any;
    logic [IDX_W-1:0] pick;
    logic [IDX_W-1:0] idx_v;
    chk_res_e         res;

    // Per-slot match: occupied, executed, younger, same coarse region.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = occ[i] && exec_vec[i] && (seq_arr[i] > st_seq) &&
                            (addr_arr[i][ADDR_W-1:GRAN_SHIFT] ==
                             st_addr[ADDR_W-1:GRAN_SHIFT]);
    end

    // Oldest match: walk from youngest to oldest so the last hit seen is the oldest.
    always_comb begin
        hit_any = 1'b0;
        pick    = '0;
        idx_v   = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            idx_v = head + IDX_W'(k);
            if (hit_vec[idx_v]) begin
                hit_any = 1'b1;
                pick    = idx_v;
            end
        end
    end

    // Classify this cycle's store check.
    always_comb begin
        if (!st_valid || sq_valid) res = CHK_NONE;
        else if (viol_valid)       res = CHK_SKIP;
        else if (hit_any)          res = CHK_HIT;
        else                       res = CHK_CLEAN;
    end

    // Register the check result and keep the violator record up to date.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_done    <= 1'b0;
            st_fault   <= 1'b0;
            viol_valid <= 1'b0;
            viol_idx   <= '0;
            viol_seq   <= '0;
        end else begin
            st_done  <= (res != CHK_NONE);
            st_fault <= (res == CHK_HIT);
            if (res == CHK_HIT) begin
                viol_valid <= 1'b1;
                viol_idx   <= pick;
                viol_seq   <= seq_arr[pick];
            end else if (viol_rd || (res == CHK_CLEAN)) begin
                viol_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ldq_order_guard.sv
// ldq_order_guard: load queue with store-versus-load ordering check.
// Ties together the ring control, the slot storage and the violation
// search, and derives the ready count and the combined free-entry figure.
// Assumes: DEPTH is a power of two and at least 2, and GRAN_SHIFT < ADDR_W.
module ldq_order_guard #(
    parameter  int DEPTH      = 8,
    parameter  int SQ_DEPTH   = 8,
    parameter  int SEQ_W      = 16,
    parameter  int ADDR_W     = 32,
    parameter  int GRAN_SHIFT = 8,
    localparam int IDX_W      = $clog2(DEPTH),
    localparam int CNT_W      = $clog2(DEPTH + 1),
    localparam int SQ_CNT_W   = $clog2(SQ_DEPTH + 1),
    localparam int FREE_W     = $clog2(((DEPTH > SQ_DEPTH) ? DEPTH : SQ_DEPTH) + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_valid,
    input  logic [SEQ_W-1:0]    alloc_seq,
    input  logic                alloc_rdy,
    output logic [IDX_W-1:0]    alloc_idx,
    output logic                lq_full,
    input  logic                upd_valid,
    input  logic [IDX_W-1:0]    upd_idx,
    input  logic [ADDR_W-1:0]   upd_addr,
    input  logic                wk_valid,
    input  logic [IDX_W-1:0]    wk_idx,
    input  logic                st_valid,
    input  logic [SEQ_W-1:0]    st_seq,
    input  logic [ADDR_W-1:0]   st_addr,
    output logic                st_done,
    output logic                st_fault,
    input  logic                viol_rd,
    output logic                viol_valid,
    output logic [IDX_W-1:0]    viol_idx,
    output logic [SEQ_W-1:0]    viol_seq,
    input  logic                cm_valid,
    input  logic [SEQ_W-1:0]    cm_seq,
    input  logic                sq_valid,
    input  logic [SEQ_W-1:0]    sq_seq,
    input  logic [SQ_CNT_W-1:0] sq_used,
    output logic [CNT_W-1:0]    ld_count,
    output logic [CNT_W-1:0]    ready_cnt,
    output logic [FREE_W-1:0]   free_slots
);

    import ldq_pkg::*;

    logic [IDX_W-1:0]  head;
    logic [IDX_W-1:0]  tail;
    logic [CNT_W-1:0]  count;
    logic              alloc_fire;
    logic [DEPTH-1:0]  occ;
    logic [SEQ_W-1:0]  seq_arr  [DEPTH];
    logic [ADDR_W-1:0] addr_arr [DEPTH];
    logic [DEPTH-1:0]  exec_vec;
    logic [DEPTH-1:0]  rdy_vec;
    int                lq_free;
    int                sq_free;
    int                min_free;

    ldq_age_ctrl #(
        .DEPTH (DEPTH),
        .SEQ_W (SEQ_W)
    ) age_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_valid (alloc_valid),
        .cm_valid    (cm_valid),
        .cm_seq      (cm_seq),
        .sq_valid    (sq_valid),
        .sq_seq      (sq_seq),
        .seq_arr     (seq_arr),
        .head        (head),
        .tail        (tail),
        .count       (count),
        .alloc_fire  (alloc_fire),
        .occ         (occ)
    );

    ldq_slot_store #(
        .DEPTH  (DEPTH),
        .SEQ_W  (SEQ_W),
        .ADDR_W (ADDR_W)
    ) slots_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_fire),
        .tail       (tail),
        .alloc_seq  (alloc_seq),
        .alloc_rdy  (alloc_rdy),
        .upd_valid  (upd_valid),
        .upd_idx    (upd_idx),
        .upd_addr   (upd_addr),
        .wk_valid   (wk_valid),
        .wk_idx     (wk_idx),
        .sq_valid   (sq_valid),
        .occ        (occ),
        .seq_arr    (seq_arr),
        .addr_arr   (addr_arr),
        .exec_vec   (exec_vec),
        .rdy_vec    (rdy_vec)
    );

    ldq_viol_search #(
        .DEPTH      (DEPTH),
        .SEQ_W      (SEQ_W),
        .ADDR_W     (ADDR_W),
        .GRAN_SHIFT (GRAN_SHIFT)
    ) search_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_valid   (st_valid),
        .st_seq     (st_seq),
        .st_addr    (st_addr),
        .sq_valid   (sq_valid),
        .viol_rd    (viol_rd),
        .head       (head),
        .occ        (occ),
        .exec_vec   (exec_vec),
        .seq_arr    (seq_arr),
        .addr_arr   (addr_arr),
        .st_done    (st_done),
        .st_fault   (st_fault),
        .viol_valid (viol_valid),
        .viol_idx   (viol_idx),
        .viol_seq   (viol_seq)
    );

    assign alloc_idx = tail;
    assign lq_full   = (count == CNT_W'(DEPTH));
    assign ld_count  = count;

    // Count occupied loads that are ready and not yet executed.
    always_comb begin
        ready_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            ready_cnt = ready_cnt + CNT_W'(occ[i] && rdy_vec[i] && !exec_vec[i]);
        end
    end

    // Combined free entries, one slot held back, floored at zero.
    always_comb begin
        lq_free    = DEPTH - int'(count);
        sq_free    = (int'(sq_used) > SQ_DEPTH) ? 0 : SQ_DEPTH - int'(sq_used);
        min_free   = lesser(lq_free, sq_free);
        free_slots = (min_free == 0) ? '0 : FREE_W'(min_free - 1);
    end

endmodule

// File: rtl/ldq_order_guard_chk.sv
// ldq_order_guard_chk: temporal properties of the load queue's ports,
// attached to every instance of the top by the bind below.
// Assumes: synchronous active-low reset, properties disabled while it is low.
module ldq_order_guard_chk #(
    parameter  int DEPTH    = 8,
    parameter  int SEQ_W    = 16,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1),
    parameter  int FREE_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_valid,
    input logic              cm_valid,
    input logic              st_valid,
    input logic              sq_valid,
    input logic              viol_rd,
    input logic              viol_valid,
    input logic [IDX_W-1:0]  viol_idx,
    input logic [SEQ_W-1:0]  viol_seq,
    input logic              st_done,
    input logic              st_fault,
    input logic              lq_full,
    input logic [CNT_W-1:0]  ld_count,
    input logic [FREE_W-1:0] free_slots
);

    // R5
    fault_has_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_fault |-> (viol_valid && st_done));

    // R6
    skip_when_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !sq_valid && viol_valid) |=> (st_done && !st_fault));

    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_rd && viol_valid) |=> !viol_valid);

    // R6
    record_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && !viol_rd) |=> (viol_valid && $stable(viol_idx) && $stable(viol_seq)));

    // R9
    squash_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |=> (ld_count <= $past(ld_count)));

    // R9
    squash_blocks_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |=> !st_done);

    // R2
    full_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_full && alloc_valid && !cm_valid && !sq_valid) |=> lq_full);

    // R10
    free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_slots) <= DEPTH - 1);

endmodule

bind ldq_order_guard ldq_order_guard_chk #(
    .DEPTH  (DEPTH),
    .SEQ_W  (SEQ_W),
    .FREE_W (FREE_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .cm_valid    (cm_valid),
    .st_valid    (st_valid),
    .sq_valid    (sq_valid),
    .viol_rd     (viol_rd),
    .viol_valid  (viol_valid),
    .viol_idx    (viol_idx),
    .viol_seq    (viol_seq),
    .st_done     (st_done),
    .st_fault    (st_fault),
    .lq_full     (lq_full),
    .ld_count    (ld_count),
    .free_slots  (free_slots)
);

// File: tb/ldq_order_guard_tb.sv
// ldq_order_guard_tb_top: compares the DUT every cycle against a behavioural
// model built on a queue of load records.
module ldq_order_guard_tb_top;

    localparam int DEPTH    = 4;
    localparam int SQ_DEPTH = 6;
    localparam int SEQ_W    = 12;
    localparam int ADDR_W   = 16;
    localparam int GRAN     = 8;
    localparam int IDX_W    = $clog2(DEPTH);
    localparam int CNT_W    = $clog2(DEPTH + 1);
    localparam int SQ_CNT_W = $clog2(SQ_DEPTH + 1);
    localparam int FREE_W   = $clog2(((DEPTH > SQ_DEPTH) ? DEPTH : SQ_DEPTH) + 1);
    localparam time CLK_PERIOD = 10ns;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                alloc_valid = 1'b0;
    logic [SEQ_W-1:0]    alloc_seq = '0;
    logic                alloc_rdy = 1'b0;
    logic [IDX_W-1:0]    alloc_idx;
    logic                lq_full;
    logic                upd_valid = 1'b0;
    logic [IDX_W-1:0]    upd_idx = '0;
    logic [ADDR_W-1:0]   upd_addr = '0;
    logic                wk_valid = 1'b0;
    logic [IDX_W-1:0]    wk_idx = '0;
    logic                st_valid = 1'b0;
    logic [SEQ_W-1:0]    st_seq = '0;
    logic [ADDR_W-1:0]   st_addr = '0;
    logic                st_done;
    logic                st_fault;
    logic                viol_rd = 1'b0;
    logic                viol_valid;
    logic [IDX_W-1:0]    viol_idx;
    logic [SEQ_W-1:0]    viol_seq;
    logic                cm_valid = 1'b0;
    logic [SEQ_W-1:0]    cm_seq = '0;
    logic                sq_valid = 1'b0;
    logic [SEQ_W-1:0]    sq_seq = '0;
    logic [SQ_CNT_W-1:0] sq_used = '0;
    logic [CNT_W-1:0]    ld_count;
    logic [CNT_W-1:0]    ready_cnt;
    logic [FREE_W-1:0]   free_slots;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ldq_order_guard #(
        .DEPTH      (DEPTH),
        .SQ_DEPTH   (SQ_DEPTH),
        .SEQ_W      (SEQ_W),
        .ADDR_W     (ADDR_W),
        .GRAN_SHIFT (GRAN)
    ) dut_i (.*);

    // Behavioural model state.
    typedef struct {
        int seq;
        int addr;
        bit done;
        bit rdy;
        int slot;
    } ld_rec_t;

    ld_rec_t mq[$];
    int    mhead = 0;
    bit    m_done = 0, m_fault = 0, m_vv = 0;
    int    m_vidx = 0, m_vseq = 0;
    int    n_checks = 0, n_errors = 0;
    string cur_req = "R1";
    bit    finished = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s (%s) %s: actual=%0d expected=%0d", req, cur_req, what, act, exp);
        end
    endtask

    function automatic int model_free();
        int lf, sf, m;
        lf = DEPTH - mq.size();
        sf = (int'(sq_used) > SQ_DEPTH) ? 0 : SQ_DEPTH - int'(sq_used);
        m  = (lf < sf) ? lf : sf;
        return (m == 0) ? 0 : m - 1;
    endfunction

    // Advance the model by one clock using the current inputs.
    task automatic model_step();
        int  aslot;
        bit  do_alloc;
        bit  hit;
        if (sq_valid) begin
            while (mq.size() > 0 && mq[mq.size() - 1].seq > int'(sq_seq)) void'(mq.pop_back());
            m_done = 0;
            m_fault = 0;
            if (viol_rd) m_vv = 0;
            return;
        end
        m_done = st_valid;
        m_fault = 0;
        if (st_valid && !m_vv) begin
            hit = 0;
            foreach (mq[j]) begin
                if (!hit && mq[j].done && mq[j].seq > int'(st_seq) &&
                    (mq[j].addr >> GRAN) == (int'(st_addr) >> GRAN)) begin
                    hit = 1;
                    m_vv = 1;
                    m_vidx = mq[j].slot;
                    m_vseq = mq[j].seq;
                end
            end
            m_fault = hit;
        end else if (viol_rd) begin
            m_vv = 0;
        end
        foreach (mq[j]) begin
            if (upd_valid && mq[j].slot == int'(upd_idx)) begin
                mq[j].addr = int'(upd_addr);
                mq[j].done = 1;
            end
            if (wk_valid && mq[j].slot == int'(wk_idx)) mq[j].rdy = 1;
        end
        aslot = (mhead + mq.size()) % DEPTH;
        do_alloc = alloc_valid && (mq.size() < DEPTH);
        if (cm_valid) begin
            while (mq.size() > 0 && mq[0].seq <= int'(cm_seq)) begin
                void'(mq.pop_front());
                mhead = (mhead + 1) % DEPTH;
            end
        end
        if (do_alloc) mq.push_back('{seq: int'(alloc_seq), addr: 0, done: 0,
                                     rdy: alloc_rdy, slot: aslot});
    endtask

    task automatic compare_all();
        int rc = 0;
        foreach (mq[j]) if (mq[j].rdy && !mq[j].done) rc++;
        chk("R2",  "alloc_idx",  int'(alloc_idx),  (mhead + mq.size()) % DEPTH);
        chk("R2",  "lq_full",    int'(lq_full),    int'(mq.size() == DEPTH));
        chk("R8",  "ld_count",   int'(ld_count),   mq.size());
        chk("R11", "ready_cnt",  int'(ready_cnt),  rc);
        chk("R10", "free_slots", int'(free_slots), model_free());
        chk("R7",  "st_done",    int'(st_done),    int'(m_done));
        chk("R5",  "st_fault",   int'(st_fault),   int'(m_fault));
        chk("R6",  "viol_valid", int'(viol_valid), int'(m_vv));
        if (m_vv) begin
            chk("R5", "viol_idx", int'(viol_idx), m_vidx);
            chk("R4", "viol_seq", int'(viol_seq), m_vseq);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; upd_valid = 0; wk_valid = 0; st_valid = 0;
        viol_rd = 0; cm_valid = 0; sq_valid = 0;
    endtask

    // One clock: model, edge, compare at the falling edge, back to idle.
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        idle();
    endtask

    task automatic do_alloc(input int s, input bit r);
        alloc_valid = 1; alloc_seq = SEQ_W'(s); alloc_rdy = r; cycle();
    endtask

    task automatic do_upd(input int i, input int a);
        upd_valid = 1; upd_idx = IDX_W'(i); upd_addr = ADDR_W'(a); cycle();
    endtask

    task automatic do_store(input int s, input int a);
        st_valid = 1; st_seq = SEQ_W'(s); st_addr = ADDR_W'(a); cycle();
    endtask

    initial begin
        int nseq;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        compare_all();
        chk("R1", "reset count", int'(ld_count), 0);
        chk("R1", "reset viol",  int'(viol_valid), 0);
        chk("R1", "reset idx",   int'(alloc_idx), 0);

        cur_req = "R2";
        do_alloc(10, 1);
        do_alloc(20, 0);
        do_alloc(30, 1);
        cur_req = "R11";
        wk_valid = 1; wk_idx = 1; cycle();
        chk("R11", "ready after wake", int'(ready_cnt), 3);
        cur_req = "R3";
        do_upd(0, 'h1234);
        do_upd(1, 'h1280);
        do_upd(2, 'h12F0);
        do_upd(3, 'h1200);
        chk("R3", "ready after updates", int'(ready_cnt), 0);
        cur_req = "R5";
        do_store(15, 'h12AA);
        chk("R5", "oldest violator idx", int'(viol_idx), 1);
        chk("R5", "fault raised", int'(st_fault), 1);
        cur_req = "R6";
        do_store(5, 'h1200);
        chk("R6", "skip no fault", int'(st_fault), 0);
        viol_rd = 1; cycle();
        chk("R6", "read clears", int'(viol_valid), 0);
        cur_req = "R7";
        do_store(30, 'h1200);
        do_store(15, 'h1300);
        chk("R7", "clean no record", int'(viol_valid), 0);
        cur_req = "R4";
        do_alloc(40, 0);
        do_store(35, 'h12FF);
        chk("R4", "unexecuted never matches", int'(st_fault), 0);
        cur_req = "R2";
        do_alloc(50, 1);
        chk("R2", "full refuses", int'(ld_count), 4);
        cur_req = "R8";
        cm_valid = 1; cm_seq = 25; cycle();
        chk("R8", "commit two", int'(ld_count), 2);
        do_alloc(50, 1);
        chk("R2", "wrap slot", int'(alloc_idx), 1);
        cur_req = "R9";
        sq_valid = 1; sq_seq = 35; alloc_valid = 1; alloc_seq = 60;
        st_valid = 1; st_seq = 1; st_addr = 'h1200; cycle();
        chk("R9", "squash two", int'(ld_count), 1);
        chk("R9", "no check in squash", int'(st_done), 0);
        cur_req = "R10";
        sq_used = 6; cycle();
        chk("R10", "floor zero", int'(free_slots), 0);
        sq_used = 4; cycle();
        chk("R10", "store side min", int'(free_slots), 1);
        sq_used = 0;

        cur_req = "R4";
        nseq = 100;
        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 40) begin
                alloc_valid = 1; alloc_seq = SEQ_W'(nseq);
                alloc_rdy = $urandom_range(0, 1) == 1; nseq += 2;
            end
            if ($urandom_range(0, 99) < 45) begin
                upd_valid = 1; upd_idx = IDX_W'($urandom_range(0, DEPTH - 1));
                upd_addr = ADDR_W'(($urandom_range(0, 3) << 8) | $urandom_range(0, 255));
            end
            if ($urandom_range(0, 99) < 30) begin
                wk_valid = 1; wk_idx = IDX_W'($urandom_range(0, DEPTH - 1));
            end
            if ($urandom_range(0, 99) < 40) begin
                st_valid = 1; st_seq = SEQ_W'(nseq - $urandom_range(1, 12));
                st_addr = ADDR_W'(($urandom_range(0, 3) << 8) | $urandom_range(0, 255));
            end
            if ($urandom_range(0, 99) < 30) viol_rd = 1;
            if ($urandom_range(0, 99) < 25) begin
                cm_valid = 1; cm_seq = SEQ_W'(nseq - $urandom_range(0, 10));
            end
            if ($urandom_range(0, 99) < 6) begin
                sq_valid = 1; sq_seq = SEQ_W'(nseq - $urandom_range(0, 10));
            end
            sq_used = SQ_CNT_W'($urandom_range(0, SQ_DEPTH));
            cycle();
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog (%s): actual=timeout expected=finish", cur_req);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule